// File: doc/BRIEF.md
# Sixteen-bit Multicycle Load/Store Core

This block is a small 16-bit processor core with eight general registers, a program counter and three condition flags (negative, zero, positive). It runs a reduced instruction set: register and immediate add, bitwise AND, bitwise invert, conditional branch, PC-relative load, base-plus-offset load and store, PC-relative address formation, a vectored trap and a return through R7. Each instruction takes one fetch cycle and one execute cycle.

The core talks to a word-addressed 16-bit memory through a request strobe, an address, write data, a write enable and read data that the memory returns combinationally in the same cycle. The top 512 words of the address space, from xFE00 upward, belong to device registers. The core flags them on a separate select line and never drives the memory write enable for them. The environment supplies both the memory and the device responses.

Trap vector x25 stops the core. It raises a halt output and makes no further memory requests until the next reset.

Top module: `tiny16_core`

## Requirements
- R1: Synchronous active-low reset clears all eight registers, sets the program counter to x3000 and sets the flags to zero-only. The first request after reset reads address x3000, and the halt output is low.
- R2: Opcode 0001 adds and opcode 0101 ANDs. Destination is bits [11:9] and first source is bits [8:6]. When bit 5 is set, the second operand is bits [4:0] sign-extended. Otherwise it is the register in bits [2:0].
- R3: Opcode 1001 writes the bitwise inverse of the register in bits [8:6] to the register in bits [11:9]. Bits [5:0] are all ones.
- R4: Add, AND, invert, both loads and address formation each set exactly one flag from the value written: negative when bit 15 is set, zero when the value is zero, positive otherwise.
- R5: Opcode 0000 holds a mask in bits [11:9] (bit 11 negative, bit 10 zero, bit 9 positive). It branches when a masked flag is set. The target is the incremented PC plus bits [8:0] sign-extended. A mask of 000 never branches and a mask of 111 always does.
- R6: Opcode 0010 loads from, and opcode 1110 writes, the incremented PC plus the sign-extended bits [8:0]. Opcode 0110 loads from the register in bits [8:6] plus bits [5:0] sign-extended. Negative offsets are supported.
- R7: Opcode 0111 writes the register in bits [11:9] to the address formed by the base register in bits [8:6] plus bits [5:0] sign-extended. The flags do not change.
- R8: Opcode 1111 with any vector other than x25 writes the incremented PC to R7. It then takes the new PC from the memory word at the zero-extended vector in bits [7:0], so a vector with bit 7 set still reads low memory.
- R9: Opcode 1100 (encoded x C1C0) copies R7 into the PC.
- R10: The device select output is high exactly when a request addresses xFE00 or above. A store to that range does not raise the memory write enable. A load from it returns the device's read data.
- R11: Trap vector x25 raises the halt output at the end of its execute cycle. From then on the core makes no request and executes nothing further until reset.
- R12: Every instruction takes exactly two clock cycles, one fetch and one execute.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_req | output | 1 | Memory or device access in this cycle |
| mem_addr | output | 16 | Word address of the access |
| mem_wdata | output | 16 | Store data |
| mem_we | output | 1 | Write strobe for ordinary memory |
| mem_rdata | input | 16 | Read data, valid in the cycle of the request |
| dev_sel | output | 1 | Access targets the device range |
| halted | output | 1 | Core has stopped on trap x25 |

## Verification
The hardest case to reach from the ports is a store into the device range. The only way to get there is a base register that holds xFE00, and that value has to be loaded from a data word before the store can run. The bench does this and counts select and write-enable activity on every cycle, so a store that leaks into memory is caught. A read at xFDFF checks the edge of the range from below. Flag behaviour cannot be seen directly, so every flag setting is made visible through a branch that skips or runs an increment whose result is then stored. A trap through vector x81 shows that the vector is zero-extended rather than sign-extended.

// File: rtl/tiny16_pkg.sv
// Shared widths, opcode values, state and selector types, and helper
// functions for the 16-bit core. Assumes a fixed 16-bit instruction word.
package tiny16_pkg;
    localparam int XLEN = 16;
    localparam int NREG = 8;
    localparam int RIDX = $clog2(NREG);

    typedef logic [XLEN-1:0] word_t;
    typedef logic [2:0]      flags_t;   // {neg, zero, pos}

    localparam logic [3:0] OPC_BR   = 4'b0000;
    localparam logic [3:0] OPC_ADD  = 4'b0001;
    localparam logic [3:0] OPC_LD   = 4'b0010;
    localparam logic [3:0] OPC_AND  = 4'b0101;
    localparam logic [3:0] OPC_LDR  = 4'b0110;
    localparam logic [3:0] OPC_STR  = 4'b0111;
    localparam logic [3:0] OPC_NOT  = 4'b1001;
    localparam logic [3:0] OPC_RET  = 4'b1100;
    localparam logic [3:0] OPC_LEA  = 4'b1110;
    localparam logic [3:0] OPC_TRAP = 4'b1111;

    typedef enum logic [1:0] {ST_FETCH, ST_EXEC, ST_HALT} seq_state_t;
    typedef enum logic [1:0] {ALU_ADD, ALU_AND, ALU_INV} alu_fn_t;
    typedef enum logic [1:0] {AG_PC, AG_PCREL, AG_BASE, AG_VEC} ag_sel_t;

    // One-hot flag vector describing a written value.
    function automatic flags_t flags_of(input word_t v);
        flags_of = {v[XLEN-1], (v == '0), (~v[XLEN-1]) & (v != '0)};
    endfunction

    function automatic word_t sx9(input logic [8:0] f);
        sx9 = {{(XLEN-9){f[8]}}, f};
    endfunction

    function automatic word_t sx6(input logic [5:0] f);
        sx6 = {{(XLEN-6){f[5]}}, f};
    endfunction

    function automatic word_t sx5(input logic [4:0] f);
        sx5 = {{(XLEN-5){f[4]}}, f};
    endfunction
endpackage

// File: rtl/tiny16_regfile.sv
// General register file: NUM registers of W bits, two combinational read
// ports and one synchronous write port. Assumes synchronous active-low reset
// clears every register.
module tiny16_regfile #(
    parameter int NUM = 8,
    parameter int W   = 16,
    localparam int AW = $clog2(NUM)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_idx_a,
    output logic [W-1:0]  rd_data_a,
    input  logic [AW-1:0] rd_idx_b,
    output logic [W-1:0]  rd_data_b
);
    logic [W-1:0] regs [NUM];

    // Clear on reset, otherwise write the addressed register.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM; i++) begin
            if (!rst_n)
                regs[i] <= '0;
            else if (wr_en && (wr_idx == AW'(i)))
                regs[i] <= wr_data;
        end
    end

    // Read ports are purely combinational.
    always_comb begin
        rd_data_a = regs[rd_idx_a];
        rd_data_b = regs[rd_idx_b];
    end
endmodule

// File: rtl/tiny16_alu.sv
// Arithmetic/logic unit for add, AND and invert. Assumes operands are
// already selected (register or sign-extended immediate) by the caller.
module tiny16_alu
    import tiny16_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_fn_t      fn,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic [W-1:0] res
);
    // Pick the result for the requested function.
    always_comb begin
        unique case (fn)
            ALU_AND: res = op_a & op_b;
            ALU_INV: res = ~op_a;
            default: res = op_a + op_b;
        endcase
    end
endmodule

// File: rtl/tiny16_agu.sv
// Address generator: forms the fetch, PC-relative, base-plus-offset or
// trap-vector address and decodes the device window at the top of the space.
// Assumes offsets arrive already sign-extended and the PC already incremented.
module tiny16_agu #(
    parameter int           W        = 16,
    parameter logic [W-1:0] DEV_BASE = 16'hFE00
) (
    input  tiny16_pkg::ag_sel_t sel,
    input  logic [W-1:0]        pc,
    input  logic [W-1:0]        base,
    input  logic [W-1:0]        off_pc,
    input  logic [W-1:0]        off_base,
    input  logic [7:0]          vec,
    input  logic                req,
    output logic [W-1:0]        addr,
    output logic                dev_hit
);
    import tiny16_pkg::*;

    // Address mux with its adders.
    always_comb begin
        unique case (sel)
            AG_PCREL: addr = pc + off_pc;
            AG_BASE:  addr = base + off_base;
            AG_VEC:   addr = {{(W-8){1'b0}}, vec};
            default:  addr = pc;
        endcase
    end

    // Device window decode, only meaningful while a request is out.
    always_comb dev_hit = req && (addr >= DEV_BASE);
endmodule

// File: rtl/tiny16_core.sv
// Two-phase (fetch, execute) 16-bit core with eight registers and one-hot
// condition flags. Assumes a memory that returns read data in the same
// cycle as the request and samples writes on the rising clock edge.
module tiny16_core
    import tiny16_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_PC = 16'h3000,
    parameter logic [XLEN-1:0] DEV_BASE = 16'hFE00,
    parameter logic [7:0]      HALT_VEC = 8'h25
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic            mem_req,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            mem_we,
    input  logic [XLEN-1:0] mem_rdata,
    output logic            dev_sel,
    output logic            halted
);
    seq_state_t state;
    word_t      pc, ir;
    flags_t     flags;

    logic [3:0] opc;
    logic is_add, is_and, is_not, is_br, is_ld, is_ldr, is_str, is_lea, is_trap, is_ret;
    logic in_exec, in_fetch, stop_trap, trap_go, take_br, wb_en;

    logic [RIDX-1:0] rf_idx_a, rf_idx_b, rf_wr_idx;
    logic            rf_wr_en;
    word_t           rd_a, rd_b, rf_wr_data, alu_b, alu_res, ag_addr, wb_val;
    alu_fn_t         alu_fn;
    ag_sel_t         ag_sel;

    // Opcode decode of the held instruction.
    always_comb begin
        opc       = ir[15:12];
        is_add    = (opc == OPC_ADD);
        is_and    = (opc == OPC_AND);
        is_not    = (opc == OPC_NOT);
        is_br     = (opc == OPC_BR);
        is_ld     = (opc == OPC_LD);
        is_ldr    = (opc == OPC_LDR);
        is_str    = (opc == OPC_STR);
        is_lea    = (opc == OPC_LEA);
        is_trap   = (opc == OPC_TRAP);
        is_ret    = (opc == OPC_RET);
        in_exec   = (state == ST_EXEC);
        in_fetch  = (state == ST_FETCH);
        stop_trap = is_trap && (ir[7:0] == HALT_VEC);
        trap_go   = in_exec && is_trap && !stop_trap;
        take_br   = in_exec && is_br && |(ir[11:9] & flags);
        wb_en     = in_exec && (is_add || is_and || is_not || is_ld || is_ldr || is_lea);
    end

    // Register read selection and second ALU operand.
    always_comb begin
        rf_idx_a = is_ret ? RIDX'(NREG-1) : ir[8:6];
        rf_idx_b = is_str ? ir[11:9] : ir[2:0];
        alu_b    = ir[5] ? sx5(ir[4:0]) : rd_b;
        alu_fn   = is_and ? ALU_AND : (is_not ? ALU_INV : ALU_ADD);
    end

    // Address source per phase and instruction.
    always_comb begin
        if (!in_exec)                        ag_sel = AG_PC;
        else if (is_ld || is_lea || is_br)   ag_sel = AG_PCREL;
        else if (is_ldr || is_str)           ag_sel = AG_BASE;
        else if (is_trap)                    ag_sel = AG_VEC;
        else                                 ag_sel = AG_PC;
    end

    // Memory port drive.
    always_comb begin
        mem_req   = in_fetch || (in_exec && (is_ld || is_ldr || is_str || (is_trap && !stop_trap)));
        mem_addr  = ag_addr;
        mem_wdata = rd_b;
        mem_we    = in_exec && is_str && !dev_sel;
        halted    = (state == ST_HALT);
    end

    // Write-back value and register write port.
    always_comb begin
        if (is_ld || is_ldr) wb_val = mem_rdata;
        else if (is_lea)     wb_val = ag_addr;
        else                 wb_val = alu_res;
        rf_wr_en   = wb_en || trap_go;
        rf_wr_idx  = trap_go ? RIDX'(NREG-1) : ir[11:9];
        rf_wr_data = trap_go ? pc : wb_val;
    end

    tiny16_regfile #(.NUM(NREG), .W(XLEN)) u_rf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(rf_wr_en), .wr_idx(rf_wr_idx), .wr_data(rf_wr_data),
        .rd_idx_a(rf_idx_a), .rd_data_a(rd_a),
        .rd_idx_b(rf_idx_b), .rd_data_b(rd_b)
    );

    tiny16_alu #(.W(XLEN)) u_alu (
        .fn(alu_fn), .op_a(rd_a), .op_b(alu_b), .res(alu_res)
    );

    tiny16_agu #(.W(XLEN), .DEV_BASE(DEV_BASE)) u_agu (
        .sel(ag_sel), .pc(pc), .base(rd_a),
        .off_pc(sx9(ir[8:0])), .off_base(sx6(ir[5:0])), .vec(ir[7:0]),
        .req(mem_req), .addr(ag_addr), .dev_hit(dev_sel)
    );

    // Sequencer: fetch latches the instruction and bumps the PC, execute
    // updates flags and redirects the PC.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_FETCH;
            pc    <= RESET_PC;
            ir    <= '0;
            flags <= 3'b010;
        end else begin
            unique case (state)
                ST_FETCH: begin
                    ir    <= mem_rdata;
                    pc    <= pc + 1'b1;
                    state <= ST_EXEC;
                end
                ST_EXEC: begin
                    if (wb_en)
                        flags <= flags_of(wb_val);
                    if (take_br)
                        pc <= ag_addr;
                    else if (trap_go)
                        pc <= mem_rdata;
                    else if (is_ret)
                        pc <= rd_a;
                    state <= (is_trap && stop_trap) ? ST_HALT : ST_FETCH;
                end
                default: state <= ST_HALT;
            endcase
        end
    end

    AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(flags) == 1); // R4
    AST_STORE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_exec && is_str) |=> $stable(flags)); // R7
    AST_TRAP_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        trap_go |=> (mem_req && mem_addr == $past(mem_rdata))); // R8
    AST_DEVICE_STORE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_addr >= DEV_BASE) |-> (dev_sel && !mem_we)); // R10
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> (halted && !mem_req)); // R11
    AST_TWO_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        in_fetch |=> in_exec); // R12
endmodule

// File: tb/tb_tiny16_core.sv
module tb_tiny16_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mem_req, mem_we, dev_sel, halted;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;

    always #5 clk = ~clk;

    tiny16_core dut (
        .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_rdata(mem_rdata),
        .dev_sel(dev_sel), .halted(halted)
    );

    // Sparse memory: x0000-x01FF and x3000-x31FF.
    logic [15:0] mem [2048];
    int n_chk = 0, n_fail = 0;
    int stray = 0, dev_hits = 0, dev_mism = 0, dev_we = 0;
    logic [15:0] wp;
    logic [15:0] rst_addr;
    logic        rst_req, rst_halt;

    function automatic bit mapped(input logic [15:0] a);
        return a[15:14] == 2'b00 && a[11:9] == 3'b000 && (a[13:12] == 2'd0 || a[13:12] == 2'd3);
    endfunction
    function automatic int idx(input logic [15:0] a);
        return int'({a[13:12], a[8:0]});
    endfunction

    always_comb begin
        if (mem_addr >= 16'hFE00)  mem_rdata = 16'h8000;
        else if (mapped(mem_addr)) mem_rdata = mem[idx(mem_addr)];
        else                       mem_rdata = 16'h0000;
    end

    always @(posedge clk) begin
        if (rst_n && mem_we) begin
            if (mapped(mem_addr)) mem[idx(mem_addr)] <= mem_wdata;
            else stray = stray + 1;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (dev_sel !== (mem_req && mem_addr >= 16'hFE00)) dev_mism = dev_mism + 1;
            if (mem_req && mem_addr >= 16'hFE00) dev_hits = dev_hits + 1;
            if (mem_we && mem_addr >= 16'hFE00) dev_we = dev_we + 1;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Instruction builders.
    function automatic logic [15:0] i_addi(int d, int s, int imm);
        return {4'b0001, 3'(d), 3'(s), 1'b1, 5'(imm)};
    endfunction
    function automatic logic [15:0] i_addr(int d, int s, int t);
        return {4'b0001, 3'(d), 3'(s), 3'b000, 3'(t)};
    endfunction
    function automatic logic [15:0] i_andi(int d, int s, int imm);
        return {4'b0101, 3'(d), 3'(s), 1'b1, 5'(imm)};
    endfunction
    function automatic logic [15:0] i_andr(int d, int s, int t);
        return {4'b0101, 3'(d), 3'(s), 3'b000, 3'(t)};
    endfunction
    function automatic logic [15:0] i_not(int d, int s);
        return {4'b1001, 3'(d), 3'(s), 6'h3F};
    endfunction
    function automatic logic [15:0] i_br(int nzp, int off);
        return {4'b0000, 3'(nzp), 9'(off)};
    endfunction
    function automatic logic [15:0] i_ldr(int d, int b, int off);
        return {4'b0110, 3'(d), 3'(b), 6'(off)};
    endfunction
    function automatic logic [15:0] i_str(int s, int b, int off);
        return {4'b0111, 3'(s), 3'(b), 6'(off)};
    endfunction
    function automatic logic [15:0] i_trap(int v);
        return {8'hF0, 8'(v)};
    endfunction

    task automatic put(input logic [15:0] w);
        mem[idx(wp)] = w;
        wp = wp + 16'd1;
    endtask
    task automatic put_pcrel(input logic [3:0] opc, input int d, input logic [15:0] tgt);
        int off;
        off = int'(tgt) - int'(wp) - 1;
        put({opc, 3'(d), 9'(off)});
    endtask
    task automatic load_ptr();
        put_pcrel(4'b0010, 6, 16'h30F0);
    endtask

    function automatic logic [15:0] slot(int k);
        return mem[idx(16'h3100 + 16'(k))];
    endfunction

    task automatic prep();
        rst_n = 1'b0;
        for (int i = 0; i < 2048; i++) mem[i] = 16'h0000;
        for (int k = 0; k < 32; k++) mem[idx(16'h3100 + 16'(k))] = 16'hA5A5;
        mem[idx(16'h30F0)] = 16'h3100;
        mem[idx(16'h30F1)] = 16'hFE00;
        mem[idx(16'h30F2)] = 16'h0000;
        mem[idx(16'h30F3)] = 16'h1234;
        wp = 16'h3000;
        stray = 0; dev_hits = 0; dev_mism = 0; dev_we = 0;
    endtask

    task automatic run(output int cyc);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        rst_addr = mem_addr; rst_req = mem_req; rst_halt = halted;
        cyc = 0;
        while (!halted && cyc < 4000) begin
            @(posedge clk);
            cyc++;
            @(negedge clk);
        end
        if (!halted) chk("R12 program did not reach halt", 16'(cyc), 16'hFFFF);
        chk("R10 no stray memory write", 16'(stray), 16'd0);
    endtask

    task automatic t_reset();
        int cyc;
        prep();
        put(i_br(3'b010, 1));
        put(i_addi(4, 4, 1));
        load_ptr();
        for (int r = 0; r < 8; r++) if (r != 6) put(i_str(r, 6, r));
        put(i_trap(16'h25));
        run(cyc);
        chk("R1 first fetch address", rst_addr, 16'h3000);
        chk("R1 request after reset", {15'd0, rst_req}, 16'd1);
        chk("R1 halt low after reset", {15'd0, rst_halt}, 16'd0);
        for (int r = 0; r < 8; r++)
            if (r != 6) chk($sformatf("R1 register %0d cleared / zero flag", r), slot(r), 16'h0000);
        chk("R12 two cycles per instruction", 16'(cyc), 16'd20);
    endtask

    task automatic t_alu();
        int cyc;
        prep();
        load_ptr();
        put(i_andi(0, 0, 0));
        put(i_addi(1, 0, 7));
        put(i_addi(2, 1, -3));
        put(i_addr(3, 1, 2));
        put(i_andr(4, 3, 1));
        put(i_andi(5, 3, -6));
        put(i_not(7, 3));
        put(i_addi(0, 1, 15));
        put(i_str(1, 6, 0)); put(i_str(2, 6, 1)); put(i_str(3, 6, 2));
        put(i_str(4, 6, 3)); put(i_str(5, 6, 4)); put(i_str(7, 6, 5));
        put(i_str(0, 6, 6));
        put(i_addi(2, 2, -16));
        put(i_str(2, 6, 7));
        put(i_trap(16'h25));
        run(cyc);
        chk("R2 add immediate", slot(0), 16'h0007);
        chk("R2 add negative immediate", slot(1), 16'h0004);
        chk("R2 add register", slot(2), 16'h000B);
        chk("R2 and register", slot(3), 16'h0003);
        chk("R2 and negative immediate", slot(4), 16'h000A);
        chk("R3 invert", slot(5), 16'hFFF4);
        chk("R2 largest immediate", slot(6), 16'h0016);
        chk("R2 smallest immediate", slot(7), 16'hFFF4);
    endtask

    task automatic cc_pre();
        put(i_andi(0, 0, 0));
    endtask
    task automatic cc_post(input int mask, input int k);
        put(i_br(mask, 1));
        put(i_addi(0, 0, 1));
        put(i_str(0, 6, k));
    endtask

    task automatic t_flags();
        int cyc;
        logic [15:0] exp [12] = '{16'd0, 16'd1, 16'd0, 16'd1, 16'd0, 16'd1,
                                  16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 16'd1};
        prep();
        load_ptr();
        cc_pre(); put(i_addi(1, 0, -1)); cc_post(3'b100, 0);
        cc_pre(); put(i_addi(1, 0, -1)); cc_post(3'b011, 1);
        cc_pre(); put(i_addi(1, 0, 0));  cc_post(3'b010, 2);
        cc_pre(); put(i_addi(1, 0, 0));  cc_post(3'b101, 3);
        cc_pre(); put(i_addi(1, 0, 5));  cc_post(3'b001, 4);
        cc_pre(); put(i_addi(1, 0, 5));  cc_post(3'b110, 5);
        cc_pre(); put_pcrel(4'b1110, 1, wp + 16'd1); cc_post(3'b001, 6);
        cc_pre(); put(i_not(1, 0));      cc_post(3'b100, 7);
        cc_pre(); put_pcrel(4'b0010, 1, 16'h30F2); cc_post(3'b010, 8);
        cc_pre(); put(i_ldr(1, 6, 31));  cc_post(3'b100, 9);
        cc_pre(); put(i_addi(1, 0, 3));  cc_post(3'b111, 10);
        cc_pre(); put(i_addi(1, 0, 3));  cc_post(3'b000, 11);
        put(i_trap(16'h25));
        run(cyc);
        for (int k = 0; k < 12; k++)
            chk($sformatf("R4 R5 flag/branch case %0d", k), slot(k), exp[k]);
    endtask

    task automatic t_addr();
        int cyc;
        logic [15:0] lea_back;
        prep();
        load_ptr();
        put_pcrel(4'b1110, 1, 16'h30F2);
        put(i_str(1, 6, 0));
        put_pcrel(4'b0010, 2, 16'h30F3);
        put(i_str(2, 6, 1));
        put(i_ldr(3, 6, -16));
        put(i_str(3, 6, 2));
        lea_back = wp - 16'd2;
        put({4'b1110, 3'd7, 9'h1FD});
        put(i_str(7, 6, 3));
        put(i_andi(4, 4, 0));
        put(i_addi(5, 4, 3));
        put(i_addi(4, 4, 2));
        put(i_addi(5, 5, -1));
        put(i_br(3'b001, -3));
        put(i_str(4, 6, 4));
        put(i_str(2, 6, 31));
        put(i_ldr(0, 6, 31));
        put(i_str(0, 6, 5));
        put(i_trap(16'h25));
        run(cyc);
        chk("R6 address formation forward", slot(0), 16'h30F2);
        chk("R6 PC-relative load", slot(1), 16'h1234);
        chk("R6 base load negative offset", slot(2), 16'h3100);
        chk("R6 address formation backward", slot(3), lea_back);
        chk("R5 backward branch loop", slot(4), 16'h0006);
        chk("R7 store at offset then reload", slot(5), 16'h1234);
    endtask

    task automatic t_store_flags();
        int cyc;
        prep();
        load_ptr();
        put(i_addi(2, 0, -5));
        put(i_addi(1, 0, 0));
        put(i_str(2, 6, 0));
        put(i_br(3'b010, 1));
        put(i_addi(3, 3, 1));
        put(i_str(3, 6, 1));
        put(i_trap(16'h25));
        run(cyc);
        chk("R7 stored value", slot(0), 16'hFFFB);
        chk("R7 store left zero flag intact", slot(1), 16'h0000);
    endtask

    task automatic t_trap();
        int cyc;
        logic [15:0] second;
        prep();
        mem[idx(16'h0020)] = 16'h0040;
        mem[idx(16'h0081)] = 16'h0040;
        wp = 16'h0040;
        put(i_addi(2, 2, 9));
        put(i_str(7, 6, 1));
        put(16'hC1C0);
        wp = 16'h3000;
        load_ptr();
        put(i_andi(2, 2, 0));
        put(i_trap(16'h20));
        put(i_str(2, 6, 0));
        second = wp;
        put(i_trap(16'h81));
        put(i_str(2, 6, 2));
        put(i_trap(16'h25));
        run(cyc);
        chk("R8 R9 trap routine ran and returned", slot(0), 16'h0009);
        chk("R8 return address saved in R7", slot(1), second + 16'd1);
        chk("R8 zero-extended vector x81", slot(2), 16'h0012);
    endtask

    task automatic t_device();
        int cyc;
        prep();
        load_ptr();
        put_pcrel(4'b0010, 3, 16'h30F1);
        put(i_addi(1, 0, 7));
        put(i_str(1, 3, 0));
        put(i_ldr(4, 3, 0));
        put(i_br(3'b100, 1));
        put(i_addi(5, 5, 1));
        put(i_ldr(2, 3, -1));
        put(i_str(4, 6, 0));
        put(i_str(5, 6, 1));
        put(i_trap(16'h25));
        run(cyc);
        chk("R10 device read data", slot(0), 16'h8000);
        chk("R4 device read set negative flag", slot(1), 16'h0000);
        chk("R10 device accesses selected", 16'(dev_hits), 16'd2);
        chk("R10 select matches window every cycle", 16'(dev_mism), 16'd0);
        chk("R10 no write enable into device window", 16'(dev_we), 16'd0);
    endtask

    task automatic t_halt();
        int cyc;
        int bad;
        prep();
        load_ptr();
        put(i_trap(16'h25));
        put(i_str(6, 6, 0));
        run(cyc);
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!halted || mem_req) bad++;
        end
        chk("R11 halt held with no requests", 16'(bad), 16'd0);
        chk("R11 nothing executed after halt", slot(0), 16'hA5A5);
    endtask

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL R12 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_alu();
        t_flags();
        t_addr();
        t_store_flags();
        t_trap();
        t_device();
        t_halt();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule